// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a bank of general-purpose I/O lines placed behind a simple register bus. The bus has an address, a write strobe, write data and read data that is valid in the same cycle. Software selects the direction of each line and can make any output open-drain. It writes output values, reads back line state and arms edge interrupts. Every line has the same controls, and line n always sits at register bit 31-n.

Input lines pass through a two-flop synchronizer. Each line can be set to report falling edges only or any change. A detected edge sets a sticky event bit, and software clears that bit by writing 1 to it. The controller drives one interrupt output, which is high while any event bit is set together with its mask bit. A line is seen only when its input buffer bit is set. Otherwise the line reads as 0 and produces no events.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, no line is driven (`pin_oe` all 0) and `irq` is 0.
- R2: Line n is held in register bit 31-n of every per-line register: setting register bit 31 affects `pin_*[0]`, and register bit 22 holds line 9.
- R3: Register word offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14 and input buffer 0x18. Direction, open-drain, mask, edge control and input buffer read back what was written. Any other address reads 0.
- R4: A direction bit of 1 makes its line an output. `pin_oe` is then set and `pin_out` carries the line's data bit. A direction bit of 0 leaves `pin_oe` clear.
- R5: When a line's open-drain bit is 1 and its data bit is 1, `pin_oe` for that line is 0. When the data bit is 0, the line is still driven low.
- R6: A data-register read returns the written bit for output lines. For input lines it returns the synchronized line value, which shows up to a read after the second rising clock edge following a change on `pin_in`.
- R7: An input whose input buffer bit is 0 reads as 0 in the data register and never sets its event bit.
- R8: An edge-control bit of 1 sets the event only on a 1-to-0 transition of the line. A 0 sets it on either transition. The event bit is set at the third rising edge after the line changes.
- R9: Event bits stay set until software writes a 1 to them. Writing 0 to an event bit leaves it unchanged.
- R10: If an edge is detected in the same cycle that a clearing write targets its event bit, the bit stays set.
- R11: `irq` is 1 exactly when some line has both its event bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, same cycle |
| pin_in | input | NUM_PINS (32) | Line inputs, index = line number |
| pin_oe | output | NUM_PINS (32) | Output enables, index = line number |
| pin_out | output | NUM_PINS (32) | Output values, index = line number |
| irq | output | 1 | Combined interrupt |

## Verification
The edge detector is tested with single rising and falling steps on lines in each edge mode. These tests separate falling-only detection from any-change detection. Steps on a line with its input buffer disabled show whether gating applies to both the data read and the event path. A clearing write placed at the exact cycle an edge is latched tells whether set or clear wins. After that, a long random run mixes line toggles with writes to every register. It checks the line outputs, the interrupt and the read data against a behavioural model on each clock, so faults in bit ordering and synchronizer latency show up as mismatches.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int unsigned GPIO_MIN_ADDR_W = 5;

   localparam logic [4:0] OFS_DIR = 5'h00;
   localparam logic [4:0] OFS_ODE = 5'h04;
   localparam logic [4:0] OFS_DAT = 5'h08;
   localparam logic [4:0] OFS_EVT = 5'h0C;
   localparam logic [4:0] OFS_MSK = 5'h10;
   localparam logic [4:0] OFS_CTL = 5'h14;
   localparam logic [4:0] OFS_IBE = 5'h18;

   typedef enum logic [2:0] {
      SEL_DIR  = 3'd0,
      SEL_ODE  = 3'd1,
      SEL_DAT  = 3'd2,
      SEL_EVT  = 3'd3,
      SEL_MSK  = 3'd4,
      SEL_CTL  = 3'd5,
      SEL_IBE  = 3'd6,
      SEL_NONE = 3'd7
   } reg_sel_e;

endpackage

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_PINS-1:0] din_seen,
   input  logic [NUM_PINS-1:0] evt_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] ode_q,
   output logic [NUM_PINS-1:0] dout_q,
   output logic [NUM_PINS-1:0] msk_q,
   output logic [NUM_PINS-1:0] ctl_q,
   output logic [NUM_PINS-1:0] ibe_q,
   output logic [NUM_PINS-1:0] evt_clr,
   output logic [DATA_W-1:0]   rdata
);

   localparam int unsigned PAD_W = DATA_W - NUM_PINS;

   reg_sel_e            sel;
   logic [NUM_PINS-1:0] wd_pin;
   logic [NUM_PINS-1:0] rd_pin;

   // Address decode: full-width match against each word offset.
   always_comb begin
      if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_ODE)) sel = SEL_ODE;
      else if (addr == ADDR_W'(OFS_DAT)) sel = SEL_DAT;
      else if (addr == ADDR_W'(OFS_EVT)) sel = SEL_EVT;
      else if (addr == ADDR_W'(OFS_MSK)) sel = SEL_MSK;
      else if (addr == ADDR_W'(OFS_CTL)) sel = SEL_CTL;
      else if (addr == ADDR_W'(OFS_IBE)) sel = SEL_IBE;
      else                               sel = SEL_NONE;
   end

   // Bus bit DATA_W-1-n belongs to line n in both directions.
   for (genvar n = 0; n < NUM_PINS; n++) begin : g_lane
      assign wd_pin[n]            = wdata[DATA_W-1-n];
      assign rdata[DATA_W-1-n]    = rd_pin[n];
   end
   if (PAD_W > 0) begin : g_pad
      assign rdata[PAD_W-1:0] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         ode_q  <= '0;
         dout_q <= '0;
         msk_q  <= '0;
         ctl_q  <= '0;
         ibe_q  <= '0;
      end else if (we) begin
         case (sel)
            SEL_DIR: dir_q  <= wd_pin;
            SEL_ODE: ode_q  <= wd_pin;
            SEL_DAT: dout_q <= wd_pin;
            SEL_MSK: msk_q  <= wd_pin;
            SEL_CTL: ctl_q  <= wd_pin;
            SEL_IBE: ibe_q  <= wd_pin;
            default: ;
         endcase
      end
   end

   assign evt_clr = (we && sel == SEL_EVT) ? wd_pin : '0;

   always_comb begin
      case (sel)
         SEL_DIR: rd_pin = dir_q;
         SEL_ODE: rd_pin = ode_q;
         SEL_DAT: rd_pin = (dir_q & dout_q) | (~dir_q & din_seen);
         SEL_EVT: rd_pin = evt_q;
         SEL_MSK: rd_pin = msk_q;
         SEL_CTL: rd_pin = ctl_q;
         SEL_IBE: rd_pin = ibe_q;
         default: rd_pin = '0;
      endcase
   end

   // R3: the direction register only moves on a write to its own offset.
   p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] sync_q,
   output logic [WIDTH-1:0] prev_q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= din;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stg[STAGES-1];
   end

   assign sync_q = stg[STAGES-1];

endmodule

// File: rtl/gpio_edge_events.sv
module gpio_edge_events #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_q,
   input  logic [WIDTH-1:0] prev_q,
   input  logic [WIDTH-1:0] ibe,
   input  logic [WIDTH-1:0] fall_only,
   input  logic [WIDTH-1:0] clr,
   input  logic [WIDTH-1:0] msk,
   output logic [WIDTH-1:0] evt_q,
   output logic             irq
);

   logic [WIDTH-1:0] hit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_det
      logic fell, rose;
      assign fell   = prev_q[i] & ~sync_q[i];
      assign rose   = ~prev_q[i] & sync_q[i];
      assign hit[i] = ibe[i] & (fell | (~fall_only[i] & rose));
   end

   // New edges take priority over a same-cycle clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~clr) | hit;
   end

   assign irq = |(evt_q & msk);

   // R9: bits not being cleared keep their value.
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(evt_q & ~clr)) == $past(evt_q & ~clr)));

   // R9: a clear without a competing edge empties the bit.
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(clr & ~hit)) == '0));

   // R10: a detected edge is always latched, clear or not.
   p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_out,
   output logic                irq
);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_edge_ctrl: NUM_PINS must be in 1..DATA_W");
   end
   if (ADDR_W < GPIO_MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_edge_ctrl: ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] dir_q, ode_q, dout_q, msk_q, ctl_q, ibe_q;
   logic [NUM_PINS-1:0] evt_q, evt_clr;
   logic [NUM_PINS-1:0] sync_q, prev_q, din_seen;

   gpio_edge_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (pin_in),
      .sync_q (sync_q),
      .prev_q (prev_q)
   );

   assign din_seen = sync_q & ibe_q;

   gpio_edge_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .din_seen (din_seen),
      .evt_q    (evt_q),
      .dir_q    (dir_q),
      .ode_q    (ode_q),
      .dout_q   (dout_q),
      .msk_q    (msk_q),
      .ctl_q    (ctl_q),
      .ibe_q    (ibe_q),
      .evt_clr  (evt_clr),
      .rdata    (bus_rdata)
   );

   gpio_edge_events #(
      .WIDTH (NUM_PINS)
   ) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_q    (sync_q),
      .prev_q    (prev_q),
      .ibe       (ibe_q),
      .fall_only (ctl_q),
      .clr       (evt_clr),
      .msk       (msk_q),
      .evt_q     (evt_q),
      .irq       (irq)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_drive
      assign pin_out[n] = dout_q[n];
      assign pin_oe[n]  = dir_q[n] & ~(ode_q[n] & dout_q[n]);
   end

   // R11: the interrupt can only rise after an event or mask change.
   p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ((evt_q != $past(evt_q)) || (msk_q != $past(msk_q))));

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pins = '0;
   logic [31:0] pin_oe, pin_out;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pins),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out),
      .irq       (irq)
   );

   // Behavioural reference: registers kept in bus bit order, line state by line number.
   bit [31:0] m_dir, m_od, m_dat, m_evt, m_msk, m_ctl, m_ibe;
   bit [31:0] m_s1, m_s2, m_pv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = 0; m_od = 0; m_dat = 0; m_evt = 0; m_msk = 0; m_ctl = 0; m_ibe = 0;
         m_s1 = 0; m_s2 = 0; m_pv = 0;
      end else begin
         bit [31:0] hit, clr;
         hit = 0; clr = 0;
         for (int n = 0; n < 32; n++) begin
            int b;
            b = 31 - n;
            if (m_ibe[b] && m_pv[n] != m_s2[n]) begin
               if (!m_ctl[b] || (m_pv[n] && !m_s2[n])) hit[b] = 1'b1;
            end
         end
         if (bus_we) begin
            case (bus_addr)
               5'h00: m_dir = bus_wdata;
               5'h04: m_od  = bus_wdata;
               5'h08: m_dat = bus_wdata;
               5'h0C: clr   = bus_wdata;
               5'h10: m_msk = bus_wdata;
               5'h14: m_ctl = bus_wdata;
               5'h18: m_ibe = bus_wdata;
               default: ;
            endcase
         end
         m_evt = (m_evt & ~clr) | hit;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
      end
   end

   function automatic bit [31:0] exp_read(bit [4:0] a);
      bit [31:0] r;
      case (a)
         5'h00: r = m_dir;
         5'h04: r = m_od;
         5'h08: begin
            for (int n = 0; n < 32; n++)
               r[31-n] = m_dir[31-n] ? m_dat[31-n] : (m_ibe[31-n] & m_s2[n]);
         end
         5'h0C: r = m_evt;
         5'h10: r = m_msk;
         5'h14: r = m_ctl;
         5'h18: r = m_ibe;
         default: r = 0;
      endcase
      return r;
   endfunction

   function automatic bit [31:0] exp_oe();
      bit [31:0] r;
      for (int n = 0; n < 32; n++)
         r[n] = m_dir[31-n] & ~(m_od[31-n] & m_dat[31-n]);
      return r;
   endfunction

   function automatic bit [31:0] exp_out();
      bit [31:0] r;
      for (int n = 0; n < 32; n++) r[n] = m_dat[31-n];
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // Per-clock comparison against the model, half a cycle after the active edge.
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R4/R5 pin_oe model", pin_oe, exp_oe());
         check("R4 pin_out model", pin_out, exp_out());
         check("R11 irq model", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
         check("R3/R6 rdata model", bus_rdata, exp_read(bus_addr));
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(bit [4:0] a, bit [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(bit [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      tick(3);
      // R1: reset state.
      check("R1 pin_oe at reset", pin_oe, 32'h0);
      check("R1 irq at reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      tick(1);
      for (int a = 0; a < 7; a++) begin
         rd(5'(a*4), v);
         check("R1 register reset value", v, 32'h0);
      end

      // R2/R4: lines 0..3 as outputs.
      wr(5'h00, 32'hF000_0000);
      tick(1);
      check("R2 R4 direction to pin_oe", pin_oe, 32'h0000_000F);
      wr(5'h08, 32'hA000_0000);
      tick(1);
      check("R2 R4 data to pin_out", pin_out & 32'hF, 32'h5);
      rd(5'h08, v);
      check("R6 data readback of outputs", v, 32'hA000_0000);
      rd(5'h1C, v);
      check("R3 unmapped address", v, 32'h0);
      wr(5'h14, 32'h1234_5678);
      rd(5'h14, v);
      check("R3 control readback", v, 32'h1234_5678);
      wr(5'h14, 32'h0);

      // R5: open drain on lines 0 and 1 (line 0 data 1, line 1 data 0).
      wr(5'h04, 32'hC000_0000);
      tick(1);
      check("R5 open-drain high released", pin_oe & 32'h3, 32'h2);

      // R7: line 8 high with input buffer off.
      pins[8] = 1'b1;
      tick(4);
      rd(5'h08, v);
      check("R7 gated input reads zero", v & 32'h0080_0000, 32'h0);
      rd(5'h0C, v);
      check("R7 gated input no event", v, 32'h0);
      wr(5'h18, 32'hFFFF_FFFF);
      tick(1);
      rd(5'h08, v);
      check("R6 enabled input reads one", v & 32'h0080_0000, 32'h0080_0000);

      // R8: line 8 falling only, line 9 both edges.
      wr(5'h14, 32'h0080_0000);
      pins[8] = 1'b0;
      tick(1);
      rd(5'h08, v);
      check("R6 two-flop latency", v & 32'h0080_0000, 32'h0080_0000);
      tick(2);
      rd(5'h0C, v);
      check("R8 falling edge on falling-only line", v, 32'h0080_0000);
      pins[8] = 1'b1;
      tick(4);
      rd(5'h0C, v);
      check("R8 rising ignored on falling-only line", v, 32'h0080_0000);
      pins[9] = 1'b1;
      tick(4);
      rd(5'h0C, v);
      check("R8 rising edge on both-edge line", v, 32'h00C0_0000);

      // R9: write 0 keeps, write 1 clears.
      wr(5'h0C, 32'h0);
      rd(5'h0C, v);
      check("R9 write zero keeps events", v, 32'h00C0_0000);
      wr(5'h0C, 32'h0040_0000);
      rd(5'h0C, v);
      check("R9 write one clears event", v, 32'h0080_0000);

      // R11: mask gating.
      check("R11 irq masked off", {31'b0, irq}, 32'h0);
      wr(5'h10, 32'h0040_0000);
      check("R11 irq other line masked", {31'b0, irq}, 32'h0);
      wr(5'h10, 32'h0080_0000);
      check("R11 irq asserted", {31'b0, irq}, 32'h1);
      wr(5'h0C, 32'h0080_0000);
      check("R11 irq drops after clear", {31'b0, irq}, 32'h0);

      // R10: clear lands on the cycle line 9's falling edge is latched.
      pins[9] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 5'h0C; bus_wdata = 32'h0040_0000; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd(5'h0C, v);
      check("R10 edge beats same-cycle clear", v, 32'h0040_0000);
      wr(5'h0C, 32'h0040_0000);
      rd(5'h0C, v);
      check("R9 later clear succeeds", v, 32'h0);

      // Random traffic, compared cycle by cycle against the model.
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) pins = pins ^ (32'h1 << $urandom_range(0, 31));
         if ($urandom_range(0, 4) == 0) begin
            bus_addr  = 5'($urandom_range(0, 7) * 4);
            bus_wdata = $urandom();
            bus_we    = 1'b1;
         end else begin
            bus_we   = 1'b0;
            bus_addr = 5'($urandom_range(0, 7) * 4);
         end
      end
      @(negedge clk);
      bus_we = 1'b0;
      tick(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule